// File: doc/BRIEF.md
# Variable-Block-Size SAD Engine

This block scores candidate macroblock positions for a block-matching motion search. For each candidate it takes sixteen rows, each row being 16 current pixels and the 16 co-located reference pixels. It accumulates the distortion of all nine partitions of the 16x16 block in a single pass: the whole block, two 16x8 halves, two 8x16 halves and four 8x8 quadrants. When the last row has arrived, a three-stage comparison pipeline does three things. It folds each partition family into a 16x16-equivalent total. It picks the smallest of the four totals. It then compares that value with the best candidate seen since the last search start.

A search controller streams the rows of one candidate after another and tags each candidate with its position. Rows arrive on a valid/ready interface. A row transfers on a clock edge where `row_valid` and `row_ready` are both high. A source that sees `row_ready` low must keep the row and `pos_tag` steady until the row is taken. `row_ready` drops for exactly one cycle after the sixteenth row of a candidate, while the accumulators are read out and emptied. It is also low in any cycle where `search_start` is high.

Control is through plain pins. `search_start` opens a new search. `best_clear` discards only the best SAD, so that the next candidate always wins. Each evaluated candidate produces a one-cycle `done` pulse. During that pulse the best registers already include the candidate's result.

Top module: `vbs_sad_engine`

## Requirements
- R1: After reset `best_sad` is 65535 (all ones), `best_pos` is 0, `done` is 0 and `row_ready` is 1.
- R2: A row transfers only on an edge where `row_valid` and `row_ready` are both high, and idle cycles between rows do not change the result. After the edge that takes row 15 of a candidate, `row_ready` is low for exactly one cycle.
- R3: The candidate SAD is the sum over all 256 pixels of |cur - ref|. Pixel c of a row sits at bits [8c+7:8c]. Rows 0-7 feed the upper 16x8 and 8x8 partitions and rows 8-15 the lower ones. Columns 0-7 feed the left 8x16 and 8x8 partitions and columns 8-15 the right ones. All four folded totals (whole, 16x8 pair, 8x16 pair, four 8x8) agree, and the largest value, 65280, is represented without overflow.
- R4: `done` is high for one cycle. It rises in the cycle that follows the third clock edge after the edge that took row 15.
- R5: A candidate replaces the best only if its SAD is strictly smaller. On a tie the earlier candidate is kept.
- R6: The position tag of a candidate is the value of `pos_tag` on the edge that takes its row 0.
- R7: `best_clear` sets `best_sad` to 65535 and leaves `best_pos` unchanged. If it falls on the edge where a candidate is being compared, that candidate is compared against 65535 and becomes the best.
- R8: `search_start` discards any partly received candidate and any candidate in the comparison pipeline, and sets `best_sad` to 65535 and `best_pos` to 0. `row_ready` is low while `search_start` is high. It takes priority over `best_clear`.
- R9: During the `done` cycle, `best_sad` and `best_pos` already include the candidate just evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_start | input | 1 | Begin a new search |
| best_clear | input | 1 | Reset the best SAD to its maximum |
| row_valid | input | 1 | A pixel row is offered |
| row_ready | output | 1 | The engine takes the offered row |
| cur_row | input | 128 | 16 current pixels, pixel c at bits [8c+7:8c] |
| ref_row | input | 128 | 16 reference pixels, same layout |
| pos_tag | input | 12 | Candidate position tag, taken with row 0 |
| done | output | 1 | One-cycle pulse per evaluated candidate |
| best_sad | output | 16 | Smallest SAD since the search start or the last clear |
| best_pos | output | 12 | Tag of the best candidate |

## Verification
Two functions can fall on the same edge: the best-register update of a finishing candidate and an external best reset. The bench asserts `best_clear` on exactly the third edge after the final row of a candidate whose SAD ties the current best. Without the clear that tie would be discarded, so the check looks for the new tag and SAD in the `done` cycle. A second case sends `search_start` while a half-sent candidate still has a row offered, and the bench checks that the row is refused and that the partial sums never reach the result. A behavioural model predicts `row_ready`, `done`, `best_sad` and `best_pos` for every cycle.

// File: rtl/vbs_sad_pkg.sv
package vbs_sad_pkg;
  // slots of the folded-total vector
  localparam int PK_WHOLE = 0;
  localparam int PK_HPAIR = 1;
  localparam int PK_VPAIR = 2;
  localparam int PK_QUAD  = 3;
  localparam int PK_COUNT = 4;
endpackage

// File: rtl/vbs_row_absdiff.sv
module vbs_row_absdiff #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  localparam int HALF = BLK / 2,
  localparam int HS_W = PIX_W + $clog2(HALF)
) (
  input  logic [BLK*PIX_W-1:0] cur_row,
  input  logic [BLK*PIX_W-1:0] ref_row,
  output logic [HS_W-1:0]      left_sum,
  output logic [HS_W-1:0]      right_sum
);
  logic [PIX_W-1:0] diff [BLK];

  for (genvar c = 0; c < BLK; c++) begin : g_pix
    logic [PIX_W-1:0] pa, pb;
    assign pa = cur_row[c*PIX_W +: PIX_W];
    assign pb = ref_row[c*PIX_W +: PIX_W];
    assign diff[c] = (pa >= pb) ? (pa - pb) : (pb - pa);
  end

  always_comb begin
    left_sum  = '0;
    right_sum = '0;
    for (int c = 0; c < HALF; c++) begin
      left_sum  = left_sum  + HS_W'(diff[c]);
      right_sum = right_sum + HS_W'(diff[c+HALF]);
    end
  end
endmodule

// File: rtl/vbs_part_accum.sv
module vbs_part_accum #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  localparam int HS_W  = PIX_W + $clog2(BLK / 2),
  localparam int SAD_W = PIX_W + 2 * $clog2(BLK),
  localparam int HP_W  = SAD_W - 1,
  localparam int Q_W   = SAD_W - 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  add_en,
  input  logic                  row_hi,
  input  logic [HS_W-1:0]       left_sum,
  input  logic [HS_W-1:0]       right_sum,
  output logic [SAD_W-1:0]      sad_whole,
  output logic [1:0][HP_W-1:0]  sad_horiz,
  output logic [1:0][HP_W-1:0]  sad_vert,
  output logic [3:0][Q_W-1:0]   sad_quad
);
  logic [HS_W:0] row_sum;
  assign row_sum = {1'b0, left_sum} + {1'b0, right_sum};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sad_whole <= '0;
    else if (flush)  sad_whole <= '0;
    else if (add_en) sad_whole <= sad_whole + SAD_W'(row_sum);
  end

  // 16x8 halves: selected by row half
  for (genvar h = 0; h < 2; h++) begin : g_horiz
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         sad_horiz[h] <= '0;
      else if (flush)                     sad_horiz[h] <= '0;
      else if (add_en && row_hi == 1'(h)) sad_horiz[h] <= sad_horiz[h] + HP_W'(row_sum);
    end
  end

  // 8x16 halves: selected by column half, every row
  for (genvar v = 0; v < 2; v++) begin : g_vert
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sad_vert[v] <= '0;
      else if (flush)  sad_vert[v] <= '0;
      else if (add_en) sad_vert[v] <= sad_vert[v] + HP_W'((v == 0) ? left_sum : right_sum);
    end
  end

  // 8x8 quadrants: index = 2*row_half + column_half
  for (genvar q = 0; q < 4; q++) begin : g_quad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              sad_quad[q] <= '0;
      else if (flush)                          sad_quad[q] <= '0;
      else if (add_en && row_hi == 1'(q / 2))  sad_quad[q] <= sad_quad[q] + Q_W'(((q % 2) == 0) ? left_sum : right_sum);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && !flush |=> sad_whole >= $past(sad_whole));
endmodule

// File: rtl/vbs_fold_cmp.sv
module vbs_fold_cmp
  import vbs_sad_pkg::*;
#(
  parameter int SAD_W = 16,
  parameter int TAG_W = 12,
  localparam int HP_W = SAD_W - 1,
  localparam int Q_W  = SAD_W - 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 clear,
  input  logic                 fold_go,
  input  logic [TAG_W-1:0]     cand_tag,
  input  logic [SAD_W-1:0]     sad_whole,
  input  logic [1:0][HP_W-1:0] sad_horiz,
  input  logic [1:0][HP_W-1:0] sad_vert,
  input  logic [3:0][Q_W-1:0]  sad_quad,
  output logic                 done,
  output logic [SAD_W-1:0]     best_sad,
  output logic [TAG_W-1:0]     best_pos
);
  logic [PK_COUNT-1:0][SAD_W-1:0] fold_c, fold_q;
  logic [SAD_W-1:0] min_c, min_q, incumbent;
  logic [TAG_W-1:0] tag_q2, tag_q3;
  logic             v2, v3;

  always_comb begin
    fold_c[PK_WHOLE] = sad_whole;
    fold_c[PK_HPAIR] = SAD_W'(sad_horiz[0]) + SAD_W'(sad_horiz[1]);
    fold_c[PK_VPAIR] = SAD_W'(sad_vert[0])  + SAD_W'(sad_vert[1]);
    fold_c[PK_QUAD]  = SAD_W'(sad_quad[0]) + SAD_W'(sad_quad[1])
                     + SAD_W'(sad_quad[2]) + SAD_W'(sad_quad[3]);
  end

  always_comb begin
    min_c = fold_q[0];
    for (int k = 1; k < PK_COUNT; k++)
      if (fold_q[k] < min_c) min_c = fold_q[k];
  end

  assign incumbent = clear ? '1 : best_sad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fold_q <= '0; min_q <= '0; tag_q2 <= '0; tag_q3 <= '0;
      v2 <= 1'b0; v3 <= 1'b0; done <= 1'b0;
      best_sad <= '1; best_pos <= '0;
    end else if (start) begin
      v2 <= 1'b0; v3 <= 1'b0; done <= 1'b0;
      best_sad <= '1; best_pos <= '0;
    end else begin
      v2 <= fold_go;
      v3 <= v2;
      done <= v3;
      if (fold_go) begin
        fold_q <= fold_c;
        tag_q2 <= cand_tag;
      end
      if (v2) begin
        min_q  <= min_c;
        tag_q3 <= tag_q2;
      end
      if (v3 && min_q < incumbent) begin
        best_sad <= min_q;
        best_pos <= tag_q3;
      end else if (clear) begin
        best_sad <= '1;
      end
    end
  end

  assert_fold_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> (fold_q[PK_HPAIR] == fold_q[PK_WHOLE]) && (fold_q[PK_VPAIR] == fold_q[PK_WHOLE])
           && (fold_q[PK_QUAD] == fold_q[PK_WHOLE]));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_best_nonincr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clear) |=> best_sad <= $past(best_sad));
  assert_clear_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !start && !v3) |=> best_sad == '1);
  assert_start_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (best_sad == '1) && (best_pos == '0) && !done);
endmodule

// File: rtl/vbs_sad_engine.sv
module vbs_sad_engine #(
  parameter int PIX_W = 8,
  parameter int BLK   = 16,
  parameter int TAG_W = 12,
  localparam int HS_W  = PIX_W + $clog2(BLK / 2),
  localparam int SAD_W = PIX_W + 2 * $clog2(BLK),
  localparam int RC_W  = $clog2(BLK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 search_start,
  input  logic                 best_clear,
  input  logic                 row_valid,
  output logic                 row_ready,
  input  logic [BLK*PIX_W-1:0] cur_row,
  input  logic [BLK*PIX_W-1:0] ref_row,
  input  logic [TAG_W-1:0]     pos_tag,
  output logic                 done,
  output logic [SAD_W-1:0]     best_sad,
  output logic [TAG_W-1:0]     best_pos
);
  logic [RC_W-1:0]  row_cnt;
  logic             fold_pend;
  logic [TAG_W-1:0] cand_tag;
  logic             take, last_row;
  logic [HS_W-1:0]  left_sum, right_sum;
  logic [SAD_W-1:0]          sad_whole;
  logic [1:0][SAD_W-2:0]     sad_horiz, sad_vert;
  logic [3:0][SAD_W-3:0]     sad_quad;

  assign row_ready = !fold_pend && !search_start;
  assign take      = row_valid && row_ready;
  assign last_row  = (row_cnt == RC_W'(BLK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cnt <= '0; fold_pend <= 1'b0; cand_tag <= '0;
    end else if (search_start) begin
      row_cnt <= '0; fold_pend <= 1'b0;
    end else begin
      fold_pend <= take && last_row;
      if (take) begin
        row_cnt <= last_row ? '0 : row_cnt + 1'b1;
        if (row_cnt == '0) cand_tag <= pos_tag;
      end
    end
  end

  vbs_row_absdiff #(.PIX_W(PIX_W), .BLK(BLK)) u_absdiff (
    .cur_row(cur_row), .ref_row(ref_row),
    .left_sum(left_sum), .right_sum(right_sum));

  vbs_part_accum #(.PIX_W(PIX_W), .BLK(BLK)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .flush(search_start || fold_pend), .add_en(take),
    .row_hi(row_cnt[RC_W-1]),
    .left_sum(left_sum), .right_sum(right_sum),
    .sad_whole(sad_whole), .sad_horiz(sad_horiz),
    .sad_vert(sad_vert), .sad_quad(sad_quad));

  vbs_fold_cmp #(.SAD_W(SAD_W), .TAG_W(TAG_W)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .start(search_start), .clear(best_clear),
    .fold_go(fold_pend), .cand_tag(cand_tag),
    .sad_whole(sad_whole), .sad_horiz(sad_horiz),
    .sad_vert(sad_vert), .sad_quad(sad_quad),
    .done(done), .best_sad(best_sad), .best_pos(best_pos));

  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last_row && !search_start) |=> !row_ready);
  assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_pend && !search_start) |=> row_ready || search_start);
endmodule

// File: tb/tb_vbs_sad_engine.sv
module tb_vbs_sad_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         search_start = 1'b0, best_clear = 1'b0, row_valid = 1'b0;
  logic         row_ready, done;
  logic [127:0] cur_row = '0, ref_row = '0;
  logic [11:0]  pos_tag = '0;
  logic [15:0]  best_sad;
  logic [11:0]  best_pos;

  int checks = 0, fails = 0;
  int cur_px [16][16];
  int ref_px [16][16];

  // behavioural model state
  int m_best = 65535, m_pos = 0, m_done = 0, m_rows = 0, m_acc = 0, m_tag = 0;
  int m_pend = 0, m_psad = 0, m_ptag = 0;

  always #2 clk = ~clk;

  vbs_sad_engine dut (
    .clk(clk), .rst_n(rst_n), .search_start(search_start), .best_clear(best_clear),
    .row_valid(row_valid), .row_ready(row_ready), .cur_row(cur_row), .ref_row(ref_row),
    .pos_tag(pos_tag), .done(done), .best_sad(best_sad), .best_pos(best_pos));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    automatic int rdy = (m_pend != 3) && !search_start;
    if (!rst_n) begin
      m_best = 65535; m_pos = 0; m_done = 0; m_rows = 0; m_acc = 0; m_pend = 0;
    end else if (search_start) begin
      m_best = 65535; m_pos = 0; m_done = 0; m_rows = 0; m_acc = 0; m_pend = 0;
    end else begin
      automatic int inc = best_clear ? 65535 : m_best;
      m_done = 0;
      if (m_pend == 1) begin
        m_done = 1;
        if (m_psad < inc) begin m_best = m_psad; m_pos = m_ptag; end
        else m_best = inc;
      end else if (best_clear) m_best = 65535;
      if (m_pend > 0) m_pend--;
      if (row_valid && rdy) begin
        if (m_rows == 0) m_tag = pos_tag;
        for (int c = 0; c < 16; c++) begin
          automatic int a = cur_row[c*8 +: 8];
          automatic int b = ref_row[c*8 +: 8];
          m_acc += (a > b) ? a - b : b - a;
        end
        m_rows++;
        if (m_rows == 16) begin
          m_pend = 3; m_psad = m_acc; m_ptag = m_tag; m_rows = 0; m_acc = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 row_ready", row_ready, (m_pend != 3) && !search_start);
      chk("R4 done", done, m_done);
      chk("R5 best_sad", best_sad, m_best);
      chk("R6 best_pos", best_pos, m_pos);
    end
  end

  function automatic int calc_sad();
    int s = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        s += (cur_px[r][c] > ref_px[r][c]) ? cur_px[r][c] - ref_px[r][c] : ref_px[r][c] - cur_px[r][c];
    return s;
  endfunction

  task automatic set_flat(input int cv, input int rv);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin cur_px[r][c] = cv; ref_px[r][c] = rv; end
  endtask

  task automatic set_quad(input int q, input int cv, input int rv);
    set_flat(50, 50);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        if ((r / 8) == (q / 2) && (c / 8) == (q % 2)) begin cur_px[r][c] = cv; ref_px[r][c] = rv; end
  endtask

  task automatic set_pattern(input int seed);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        cur_px[r][c] = (r * 37 + c * 11 + seed * 101) % 256;
        ref_px[r][c] = (r * 53 + c * 7 + seed * 29) % 256;
      end
  endtask

  task automatic send_rows(input int tag, input int nrows, input int gap);
    for (int r = 0; r < nrows; r++) begin
      logic rdy;
      for (int c = 0; c < 16; c++) begin
        cur_row[c*8 +: 8] = 8'(cur_px[r][c]);
        ref_row[c*8 +: 8] = 8'(ref_px[r][c]);
      end
      pos_tag = 12'(tag);
      row_valid = 1'b1;
      do begin
        rdy = row_ready;
        @(posedge clk); #1;
      end while (!rdy);
      row_valid = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done && n < 100) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 best_sad", best_sad, 65535);
    chk("R1 best_pos", best_pos, 0);
    chk("R1 done", done, 0);
    chk("R1 row_ready", row_ready, 1);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    set_quad(0, 100, 90); exp = calc_sad();
    send_rows(5, 16, 0); wait_done();
    chk("R3 upper-left SAD", best_sad, 640);
    chk("R3 SAD model", exp, 640);
    chk("R9 pos", best_pos, 5);

    set_quad(3, 60, 65);
    send_rows(6, 16, 0); wait_done();
    chk("R5 smaller wins sad", best_sad, 320);
    chk("R9 pos", best_pos, 6);

    set_quad(1, 70, 65);
    send_rows(7, 16, 1); wait_done();
    chk("R5 tie keeps earlier", best_pos, 6);
    chk("R2 gaps sad", best_sad, 320);

    set_flat(255, 0);
    send_rows(8, 16, 0); wait_done();
    chk("R3 max candidate not taken", best_sad, 320);

    @(posedge clk); #1 best_clear = 1'b1;
    @(posedge clk); #1 best_clear = 1'b0;
    @(negedge clk);
    chk("R7 clear sad", best_sad, 65535);
    chk("R7 clear keeps pos", best_pos, 6);

    set_quad(2, 10, 30);
    send_rows(9, 16, 0); wait_done();
    chk("R7 after clear", best_sad, 1280);
    chk("R7 after clear pos", best_pos, 9);

    set_flat(60, 55);
    send_rows(10, 16, 0);
    @(posedge clk); #1;
    @(posedge clk); #1 best_clear = 1'b1;
    @(posedge clk); #1 best_clear = 1'b0;
    @(negedge clk);
    chk("R7 clear on update done", done, 1);
    chk("R7 clear on update pos", best_pos, 10);
    chk("R7 clear on update sad", best_sad, 1280);

    set_pattern(3);
    send_rows(11, 8, 0);
    search_start = 1'b1; row_valid = 1'b1;
    @(negedge clk);
    chk("R8 ready low in start", row_ready, 0);
    @(posedge clk); #1 search_start = 1'b0; row_valid = 1'b0;
    @(negedge clk);
    chk("R8 start sad", best_sad, 65535);
    chk("R8 start pos", best_pos, 0);
    set_pattern(4); exp = calc_sad();
    send_rows(12, 16, 0); wait_done();
    chk("R8 fresh candidate sad", best_sad, exp);
    chk("R8 fresh candidate pos", best_pos, 12);

    for (int s = 5; s < 9; s++) begin
      set_pattern(s);
      send_rows(8 + s, 16, s % 2);
      wait_done();
    end
    set_flat(0, 255);
    send_rows(20, 16, 0); wait_done();
    repeat (4) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule